// File: doc/BRIEF.md
# Auxiliary Timestamp Snapshot Capture

This block latches the running system time whenever one of two external trigger pins rises. Each trigger pin has its own capture channel holding a 64-bit snapshot, read as two 32-bit words. Time values are taken unchanged from the time counter, in the same 32 ns tick units the counter counts in.

A capture raises a per-channel flag in an event word. The channels share that word with a pulse-per-second indication supplied by a neighbouring block. Flags are cleared by writing ones to them. A control word holds one interrupt mask bit per flag. A single interrupt line is asserted while any flag is set and its mask bit is set.

A snapshot stays frozen while its flag is set. Software reads the upper word, then the lower word, and then acknowledges the flag. That sequence can never see a half-updated value.

Top module: `aux_snap_capture`

## Requirements
- R1: After reset, every register word reads zero and `irq_o` is low.
- R2: A trigger input passes through a two-flop synchroniser and an edge detector. A low-to-high transition that is first sampled high at clock edge k loads the snapshot from `time_i` as sampled at edge k+2. A trigger that stays high, or falls, causes no capture.
- R3: Channel 0 capture: a capture on `trig_i[0]` sets event bit 2. The snapshot reads at word 2 (bits 63:32) and word 3 (bits 31:0).
- R4: Channel 1 capture: a capture on `trig_i[1]` sets event bit 3. The snapshot reads at word 4 (bits 63:32) and word 5 (bits 31:0).
- R5: While a channel's event bit is set, further trigger edges on that channel leave its snapshot unchanged.
- R6: Word 1 is the event word. Writing a 1 to event bit 2, 3 or 4 clears that bit, and writing 0 leaves it unchanged.
- R7: A clear and a new capture can land on the same channel in the same cycle. In that case the capture is taken, the snapshot is loaded and the event bit stays set.
- R8: A one-cycle pulse on `pps_i` sets event bit 4.
- R9: Word 0 is the control word. Bits 2, 3 and 4 are writable mask bits and all other bits read zero. `irq_o` is high exactly when some event bit b in {2,3,4} and control bit b are both set.
- R10: Writes to words 2 to 5 have no effect. Words 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 2 | Asynchronous trigger pins, one per channel |
| time_i | input | 64 | Current system time in ticks |
| pps_i | input | 1 | One-cycle pulse-per-second event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt, high while any enabled event is set |

## Verification
The bench builds the block with its default parameters: 64-bit time, 32-bit words and two synchroniser stages. The time counter starts just below a 32-bit carry, so captures taken before and after the carry exercise both snapshot halves. Two synchroniser stages fix the capture point two edges after the first sampling edge. That lets the bench line up a clear with a capture in the same cycle, and it compares every register word and the interrupt against its reference on every clock.

// File: rtl/aux_snap_pkg.sv
`timescale 1ns/1ps
package aux_snap_pkg;
  localparam int unsigned NUM_CH     = 2;
  localparam int unsigned EVT_BASE   = 2;                  // first flag bit
  localparam int unsigned PPS_BIT    = EVT_BASE + NUM_CH;  // pps flag bit
  localparam int unsigned EV_W       = NUM_CH + 1;
  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_EVT   = 1;
  localparam int unsigned ADDR_SNAP0 = 2;                  // hi, lo pairs follow
endpackage

// File: rtl/aux_snap_edge.sv
`timescale 1ns/1ps
module aux_snap_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  AST_RISE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/aux_snap_chan.sv
`timescale 1ns/1ps
module aux_snap_chan #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              pend_i,
  input  logic              ack_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              cap_o,
  output logic [TIME_W-1:0] snap_o
);
  // ack in the same cycle reopens the channel: capture wins
  assign cap_o = rise_i & (~pend_i | ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    snap_o <= '0;
    else if (cap_o) snap_o <= time_i;
  end

  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && !ack_i) |=> $stable(snap_o)); // R5
  AST_SNAP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> (snap_o == $past(time_i))); // R7
endmodule

// File: rtl/aux_snap_regs.sv
`timescale 1ns/1ps
module aux_snap_regs
  import aux_snap_pkg::*;
#(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned TIME_W = 64
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [REG_W-1:0]               wdata_i,
  input  logic [NUM_CH-1:0]              cap_i,
  input  logic                           pps_i,
  input  logic [NUM_CH-1:0][TIME_W-1:0]  snap_i,
  output logic [NUM_CH-1:0]              pend_o,
  output logic [NUM_CH-1:0]              ack_o,
  output logic [REG_W-1:0]               rdata_o,
  output logic                           irq_o
);
  localparam int unsigned HI_W = TIME_W - REG_W;

  logic [EV_W-1:0] evt_q, ctrl_q, ack_v, set_v;
  logic            wr_ctrl, wr_evt;
  logic            unused_wbits;

  assign wr_ctrl = wr_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign wr_evt  = wr_i && (addr_i == ADDR_W'(ADDR_EVT));
  assign ack_v   = wr_evt ? wdata_i[PPS_BIT:EVT_BASE] : '0;
  assign set_v   = {pps_i, cap_i};
  assign unused_wbits = ^{wdata_i[REG_W-1:PPS_BIT+1], wdata_i[EVT_BASE-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= '0;
      ctrl_q <= '0;
    end else begin
      evt_q <= (evt_q & ~ack_v) | set_v;
      if (wr_ctrl) ctrl_q <= wdata_i[PPS_BIT:EVT_BASE];
    end
  end

  assign pend_o = evt_q[NUM_CH-1:0];
  assign ack_o  = ack_v[NUM_CH-1:0];
  assign irq_o  = |(evt_q & ctrl_q);

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_CTRL)) rdata_o[PPS_BIT:EVT_BASE] = ctrl_q;
    if (addr_i == ADDR_W'(ADDR_EVT))  rdata_o[PPS_BIT:EVT_BASE] = evt_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(ADDR_SNAP0 + 2*c))
        rdata_o = REG_W'(snap_i[c][TIME_W-1:TIME_W-HI_W]);
      if (addr_i == ADDR_W'(ADDR_SNAP0 + 2*c + 1))
        rdata_o = snap_i[c][REG_W-1:0];
    end
  end

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_v != '0) |=> ((evt_q & $past(ack_v & ~set_v)) == '0)); // R6
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_v != '0) |=> ((evt_q & $past(set_v)) == $past(set_v))); // R7
  AST_PPS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pps_i |=> evt_q[EV_W-1]); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q == '0) |-> !irq_o); // R9
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> $stable(ctrl_q)); // R9
endmodule

// File: rtl/aux_snap_capture.sv
`timescale 1ns/1ps
module aux_snap_capture
  import aux_snap_pkg::*;
#(
  parameter int unsigned TIME_W      = 64,
  parameter int unsigned REG_W       = 32,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] trig_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              pps_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0]             rise, pend, ack, cap;
  logic [NUM_CH-1:0][TIME_W-1:0] snap;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    aux_snap_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (trig_i[c]),
      .rise_o  (rise[c])
    );
    aux_snap_chan #(.TIME_W(TIME_W)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rise_i (rise[c]),
      .pend_i (pend[c]),
      .ack_i  (ack[c]),
      .time_i (time_i),
      .cap_o  (cap[c]),
      .snap_o (snap[c])
    );
  end

  aux_snap_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .TIME_W(TIME_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .cap_i   (cap),
    .pps_i   (pps_i),
    .snap_i  (snap),
    .pend_o  (pend),
    .ack_o   (ack),
    .rdata_o (reg_rdata_o),
    .irq_o   (irq_o)
  );
endmodule

// File: tb/tb_aux_snap_capture.sv
`timescale 1ns/1ps
module tb_aux_snap_capture;
  import aux_snap_pkg::*;
  localparam int TIME_W = 64, REG_W = 32, ADDR_W = 3, SYNC = 2;

  logic              clk = 0, rst_ni = 0, pps = 0, reg_wr = 0, irq;
  logic [NUM_CH-1:0] trig = '0;
  logic [TIME_W-1:0] tval = 64'h0000_0001_FFFF_FF00;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [REG_W-1:0]  reg_wdata = '0, rdata;

  int nchk = 0, nerr = 0;
  bit done = 0;

  aux_snap_capture #(.TIME_W(TIME_W), .REG_W(REG_W), .ADDR_W(ADDR_W),
                     .SYNC_STAGES(SYNC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .trig_i(trig), .time_i(tval), .pps_i(pps),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(rdata), .irq_o(irq));

  always #2 clk = ~clk;  // 250 MHz

  always begin
    @(negedge clk); #1;
    tval = tval + 1;
  end

  // reference model
  bit [31:0]       m_ctrl, m_evt;
  bit [63:0]       m_snap [NUM_CH];
  bit [7:0]        m_hist [NUM_CH];

  always @(posedge clk or negedge rst_ni) begin : model
    bit [31:0] clr, setv;
    if (!rst_ni) begin
      m_ctrl = 0; m_evt = 0;
      for (int c = 0; c < NUM_CH; c++) begin m_snap[c] = 0; m_hist[c] = 0; end
    end else begin
      clr  = (reg_wr && reg_addr == 1) ? (reg_wdata & 32'h1C) : 0;
      setv = 0;
      for (int c = 0; c < NUM_CH; c++) begin
        if (m_hist[c][SYNC-1] && !m_hist[c][SYNC] && (!m_evt[2+c] || clr[2+c])) begin
          m_snap[c] = tval;
          setv[2+c] = 1;
        end
        m_hist[c] = {m_hist[c][6:0], trig[c]};
      end
      if (pps) setv[4] = 1;
      if (reg_wr && reg_addr == 0) m_ctrl = reg_wdata & 32'h1C;
      m_evt = (m_evt & ~clr) | setv;
    end
  end

  function automatic bit [31:0] exp_rd(int a);
    case (a)
      0: return m_ctrl;
      1: return m_evt;
      2: return m_snap[0][63:32];
      3: return m_snap[0][31:0];
      4: return m_snap[1][63:32];
      5: return m_snap[1][31:0];
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R9";
      1: return "R6";
      2, 3: return "R3";
      4, 5: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      check(tag_of(int'(reg_addr)), rdata, exp_rd(int'(reg_addr)));
      check("R9", {31'b0, irq}, {31'b0, |(m_ctrl & m_evt)});
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(int a, bit [31:0] d);
    reg_addr = ADDR_W'(a); reg_wdata = d; reg_wr = 1;
    step();
    reg_wr = 0;
  endtask

  task automatic rd_chk(string tag, int a, bit [31:0] e);
    reg_addr = ADDR_W'(a); #0.2;
    check(tag, rdata, e);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1; nerr++; nchk++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    bit [31:0] old_lo;
    repeat (3) step();
    for (int a = 0; a < 8; a++) rd_chk("R1", a, 0);
    check("R1", {31'b0, irq}, 0);
    rst_ni = 1;
    step();

    // R9: only mask bits stick
    wr(0, 32'hFFFF_FFFF);
    rd_chk("R9", 0, 32'h1C);
    wr(0, 32'h0C);

    // R3: channel 0 capture
    trig[0] = 1;
    repeat (4) step();
    rd_chk("R3", 1, 32'h4);
    check("R3", {31'b0, irq}, 1);
    rd_chk("R3", 2, m_snap[0][63:32]);
    rd_chk("R3", 3, m_snap[0][31:0]);
    old_lo = rdata;

    // R5: new edge while pending is ignored
    trig[0] = 0; repeat (3) step();
    trig[0] = 1; repeat (4) step();
    rd_chk("R5", 3, old_lo);

    // R6: write 0 keeps, write 1 clears
    wr(1, 32'h0);
    rd_chk("R6", 1, 32'h4);
    wr(1, 32'h4);
    rd_chk("R6", 1, 32'h0);
    check("R6", {31'b0, irq}, 0);

    // R2: steady high and falling edge do not capture
    repeat (4) step();
    rd_chk("R2", 1, 32'h0);
    trig[0] = 0; repeat (4) step();
    rd_chk("R2", 1, 32'h0);

    // R4: channel 1 capture
    trig[1] = 1; repeat (4) step();
    rd_chk("R4", 1, 32'h8);
    rd_chk("R4", 4, m_snap[1][63:32]);
    rd_chk("R4", 5, m_snap[1][31:0]);

    // R8: pps flag, R9 masking
    pps = 1; step(); pps = 0; step();
    rd_chk("R8", 1, 32'h18);
    wr(1, 32'h8);
    rd_chk("R8", 1, 32'h10);
    check("R9", {31'b0, irq}, 0);
    wr(0, 32'h10);
    check("R9", {31'b0, irq}, 1);
    wr(1, 32'h10);
    wr(0, 32'h1C);

    // R7: clear and capture in the same cycle
    trig[1] = 0; repeat (3) step();
    trig[1] = 1; repeat (4) step();
    rd_chk("R7", 5, m_snap[1][31:0]);
    old_lo = rdata;
    trig[1] = 0; repeat (3) step();
    trig[1] = 1; step(); step();
    wr(1, 32'h8);
    rd_chk("R7", 1, 32'h8);
    rd_chk("R7", 5, m_snap[1][31:0]);
    check("R7", {31'b0, rdata != old_lo}, 1);

    // R10: snapshot words read-only, unmapped words zero
    for (int a = 2; a < 6; a++) wr(a, 32'hDEAD_BEEF);
    for (int a = 2; a < 6; a++) rd_chk("R10", a, exp_rd(a));
    rd_chk("R10", 6, 0);
    rd_chk("R10", 7, 0);

    // mixed traffic, compared every clock
    for (int i = 0; i < 3000; i++) begin
      trig = NUM_CH'($urandom);
      pps  = ($urandom % 16) == 0;
      reg_addr = ADDR_W'($urandom % 8);
      if (($urandom % 6) == 0) begin
        reg_wr = 1;
        reg_wdata = (($urandom % 4) == 0) ? $urandom : 32'h1C & $urandom;
      end else reg_wr = 0;
      step();
    end
    reg_wr = 0; pps = 0;
    step();
    done = 1;
    report();
  end
endmodule